// File: doc/BRIEF.md
# Sampling ADC Host Interface Controller

This block sits on the host side of a 12-bit parallel sampling converter and runs one full conversion-and-read sequence per start request. A start request usually comes from a system timer. The controller then pulls the convert strobe low for a programmable number of clocks. While the strobe is low, the converter's sampler settles into hold. Conversion begins on the rising edge of the strobe. The controller then watches the converter's busy line fall and come back high. After that it asserts chip-select and read together, waits a fixed number of clocks for the bus to settle, and captures the 12-bit result.

The result can be presented in two framings. In word framing it is a single left-justified 16-bit word. In byte framing it is two successive byte loads for a narrow host, with a byte-select flag that names the byte on the bus. A one-clock done pulse marks the moment the formatted result is registered, and the result holds until the next conversion finishes.

A programmable gap enforces the converter's acquisition time before the next sample. Starts that arrive at a bad moment are dropped and recorded in a sticky overrun flag. A missing busy edge aborts the sequence and sets a sticky timeout flag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted, and on leaving it, the convert, chip-select and read strobes are high (inactive), and data_vld, done, overrun and timeout_err are 0.
- R2: An accepted start drives the convert strobe low for exactly hold_cycles clocks, with a value of 0 treated as 1. The strobe then returns high and stays high for the rest of the sequence.
- R3: Chip-select and read go low together only after busy has fallen and risen again. They stay low for exactly RD_WAIT clocks, and the convert strobe is high throughout.
- R4: With byte_mode = 0, one load is made (data_vld high for one clock, byte_hi = 0). data_out = {result[11:0], 4'b0000}, with the code passed as straight binary.
- R5: With byte_mode = 1, two loads are made on consecutive clocks. The first has byte_hi = 1 and data_out = {8'h00, result[11:4]}. The second has byte_hi = 0 and data_out = {8'h00, result[3:0], 4'b0000}.
- R6: done is high for exactly one clock per completed conversion, on the clock of the final load. data_out holds its value after that clock.
- R7: A start request is ignored if it arrives while a sequence is in progress or the spacing gap is still running. It sets overrun, and overrun stays set until reset.
- R8: After busy rises, the next convert strobe fall comes no earlier than gap_cycles clocks later.
- R9: If busy does not fall within TMO clocks after the convert strobe rises, the sequence aborts with no read and no done, and timeout_err is set and stays set until reset.
- R10: If busy does not rise within TMO clocks after it falls, the sequence aborts with no read and no done, and timeout_err is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request to begin a conversion |
| byte_mode | input | 1 | 0: one 16-bit word, 1: two byte loads (latched at start) |
| hold_cycles | input | CW | Convert strobe low width in clocks |
| gap_cycles | input | CW | Minimum clocks from busy rising to the next convert strobe |
| adc_convst_n | output | 1 | Convert strobe to the converter, active low |
| adc_busy_n | input | 1 | Converter busy, low while converting |
| adc_cs_n | output | 1 | Chip-select to the converter, active low |
| adc_rd_n | output | 1 | Read strobe to the converter, active low |
| adc_data | input | 12 | Converter data bus |
| data_out | output | 16 | Formatted result |
| data_vld | output | 1 | One-clock pulse per load on data_out |
| byte_hi | output | 1 | 1 when data_out holds the high byte |
| done | output | 1 | One-clock pulse when the result is complete |
| overrun | output | 1 | Sticky: a start request was dropped |
| timeout_err | output | 1 | Sticky: a busy edge never arrived |

## Verification
Randomized sequences vary the hold width, the gap, the framing, the code and the converter's busy delays. Mismatches therefore show up as a wrong low width, a wrong read window or a wrong bit placement, rather than lining up by chance. Directed codes 0x000 and 0xFFF check that the ends of the range survive both framings, and a hold value of 0 checks the one-clock floor. A start held high through the gap shows whether the spacing is measured from busy rising. A stray start during conversion shows that a request is dropped without disturbing the sequence in progress. A converter that never drops busy, and one that never raises it, tell the two timeout windows apart.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CW      = 8,
  parameter int RD_WAIT = 3,
  parameter int TMO     = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          byte_mode,
  input  logic [CW-1:0] hold_cycles,
  input  logic [CW-1:0] gap_cycles,
  output logic          adc_convst_n,
  input  logic          adc_busy_n,
  output logic          adc_cs_n,
  output logic          adc_rd_n,
  input  logic [11:0]   adc_data,
  output logic [15:0]   data_out,
  output logic          data_vld,
  output logic          byte_hi,
  output logic          done,
  output logic          overrun,
  output logic          timeout_err
);

  localparam int TW  = $clog2(TMO + 1);
  localparam int RW  = $clog2(RD_WAIT + 1);
  localparam int KW0 = (TW > CW) ? TW : CW;
  localparam int KW  = (KW0 > RW) ? KW0 : RW;
  localparam logic [KW-1:0] TMO_LD = KW'(TMO - 1);
  localparam logic [KW-1:0] RD_LD  = KW'(RD_WAIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_WFALL, S_WRISE, S_READ, S_BYTE2} st_t;

  st_t           st;
  logic [KW-1:0] cnt;
  logic [CW-1:0] gap_cnt;
  logic          mode_q;
  logic [3:0]    lo_nib;

  wire           ready   = (st == S_IDLE) && (gap_cnt == '0);
  wire [KW-1:0]  hold_ld = (hold_cycles == '0) ? '0 : KW'(hold_cycles - CW'(1));

  assign adc_convst_n = (st != S_LOW);
  assign adc_cs_n     = (st != S_READ);
  assign adc_rd_n     = (st != S_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      gap_cnt     <= '0;
      mode_q      <= 1'b0;
      lo_nib      <= '0;
      data_out    <= '0;
      data_vld    <= 1'b0;
      byte_hi     <= 1'b0;
      done        <= 1'b0;
      overrun     <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      data_vld <= 1'b0;
      done     <= 1'b0;
      if (gap_cnt != '0) gap_cnt <= gap_cnt - CW'(1);
      if (start_req && !ready) overrun <= 1'b1;
      case (st)
        S_IDLE:
          if (start_req && ready) begin
            st     <= S_LOW;
            cnt    <= hold_ld;
            mode_q <= byte_mode;
          end
        S_LOW:
          if (cnt == '0) begin
            st  <= S_WFALL;
            cnt <= TMO_LD;
          end else cnt <= cnt - KW'(1);
        S_WFALL:
          if (!adc_busy_n) begin
            st  <= S_WRISE;
            cnt <= TMO_LD;
          end else if (cnt == '0) begin
            st          <= S_IDLE;
            timeout_err <= 1'b1;
          end else cnt <= cnt - KW'(1);
        S_WRISE:
          if (adc_busy_n) begin
            st      <= S_READ;
            cnt     <= RD_LD;
            gap_cnt <= gap_cycles;
          end else if (cnt == '0) begin
            st          <= S_IDLE;
            timeout_err <= 1'b1;
          end else cnt <= cnt - KW'(1);
        S_READ:
          if (cnt == '0) begin
            lo_nib   <= adc_data[3:0];
            data_vld <= 1'b1;
            if (mode_q) begin
              data_out <= {8'h00, adc_data[11:4]};
              byte_hi  <= 1'b1;
              st       <= S_BYTE2;
            end else begin
              data_out <= {adc_data, 4'h0};
              byte_hi  <= 1'b0;
              done     <= 1'b1;
              st       <= S_IDLE;
            end
          end else cnt <= cnt - KW'(1);
        S_BYTE2: begin
          data_out <= {8'h00, lo_nib, 4'h0};
          byte_hi  <= 1'b0;
          data_vld <= 1'b1;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_read_outside_convst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> adc_convst_n);
  assert_word_low_nibble_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !byte_hi) |-> (data_out[3:0] == 4'h0));
  assert_byte_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_vld && byte_hi) |=> (data_vld && !byte_hi && done));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_gap_before_convst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_convst_n) |-> ($past(gap_cnt) == '0));
  assert_timeout_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
  assert_timeout_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> adc_cs_n);

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int CW = 8, RD_WAIT = 3, TMO = 64;

  logic clk = 1'b0, rst_n = 1'b0, start_req = 1'b0, byte_mode = 1'b0;
  logic [CW-1:0] hold_cycles = 8'd2, gap_cycles = 8'd0;
  logic adc_convst_n, adc_busy_n, adc_cs_n, adc_rd_n;
  logic [11:0] adc_data, code = 12'h000;
  logic [15:0] data_out;
  logic data_vld, byte_hi, done, overrun, timeout_err;

  adc_seq_ctrl #(.CW(CW), .RD_WAIT(RD_WAIT), .TMO(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .byte_mode(byte_mode),
    .hold_cycles(hold_cycles), .gap_cycles(gap_cycles), .adc_convst_n(adc_convst_n),
    .adc_busy_n(adc_busy_n), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_data(adc_data),
    .data_out(data_out), .data_vld(data_vld), .byte_hi(byte_hi), .done(done),
    .overrun(overrun), .timeout_err(timeout_err));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model
  int fall_dly = 2, rise_dly = 5, ph = 0, mcnt = 0;
  bit fall_en = 1'b1, rise_en = 1'b1;
  logic cv_prev = 1'b1;
  assign adc_data = !adc_rd_n ? code : 12'h5A5;

  always @(negedge clk) begin
    if (!rst_n) begin
      adc_busy_n <= 1'b1;
      ph <= 0;
    end else begin
      case (ph)
        0: if (!cv_prev && adc_convst_n && fall_en) begin ph <= 1; mcnt <= fall_dly; end
        1: if (mcnt <= 1) begin adc_busy_n <= 1'b0; ph <= rise_en ? 2 : 3; mcnt <= rise_dly; end
           else mcnt <= mcnt - 1;
        2: if (mcnt <= 1) begin adc_busy_n <= 1'b1; ph <= 0; end else mcnt <= mcnt - 1;
        default: if (rise_en) begin adc_busy_n <= 1'b1; ph <= 0; end
      endcase
    end
    cv_prev <= adc_convst_n;
  end

  // monitor
  int cyc = 0, lowrun = 0, last_low = 0, nlow = 0, csrun = 0, last_cs = 0, ncs = 0;
  int nload = 0, ndone = 0, t_rise = 0, t_fall = 0;
  logic [16:0] ld [2];
  logic mb_prev = 1'b1, mc_prev = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (!adc_convst_n) lowrun++;
    else if (lowrun != 0) begin last_low = lowrun; lowrun = 0; nlow++; end
    if (!adc_cs_n && !adc_rd_n) csrun++;
    else if (csrun != 0) begin last_cs = csrun; csrun = 0; ncs++; end
    if (data_vld) begin ld[nload % 2] = {byte_hi, data_out}; nload++; end
    if (done) ndone++;
    if (!mb_prev && adc_busy_n === 1'b1) t_rise = cyc;
    if (mc_prev && !adc_convst_n) t_fall = cyc;
    mb_prev = adc_busy_n;
    mc_prev = adc_convst_n;
  end

  function automatic logic [16:0] exp_word(input logic [11:0] c);
    return {1'b0, c, 4'h0};
  endfunction
  function automatic logic [16:0] exp_hi(input logic [11:0] c);
    return {1'b1, 8'h00, c[11:4]};
  endfunction
  function automatic logic [16:0] exp_lo(input logic [11:0] c);
    return {1'b0, 8'h00, c[3:0], 4'h0};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      #1;
      if (ndone > d0) break;
    end
  endtask

  task automatic run_conv(input int h, input int g, input bit m, input logic [11:0] c,
                          input int fd, input int rd, input bit stray);
    int l0, d0;
    logic [15:0] held;
    @(negedge clk);
    hold_cycles = CW'(h); gap_cycles = CW'(g); byte_mode = m; code = c;
    fall_dly = fd; rise_dly = rd;
    l0 = nload; d0 = ndone;
    pulse_start();
    if (stray) begin
      repeat (h + 2) @(negedge clk);
      pulse_start();
    end
    wait_done(d0);
    chk(ndone == d0 + 1, "R6 done count", ndone - d0, 1);
    chk(last_low == ((h == 0) ? 1 : h), "R2 convst low width", last_low, (h == 0) ? 1 : h);
    chk(last_cs == RD_WAIT, "R3 cs/rd low width", last_cs, RD_WAIT);
    if (!m) begin
      chk(nload == l0 + 1, "R4 load count", nload - l0, 1);
      chk(ld[l0 % 2] == exp_word(c), "R4 word", ld[l0 % 2], exp_word(c));
    end else begin
      chk(nload == l0 + 2, "R5 load count", nload - l0, 2);
      chk(ld[l0 % 2] == exp_hi(c), "R5 high byte", ld[l0 % 2], exp_hi(c));
      chk(ld[(l0 + 1) % 2] == exp_lo(c), "R5 low byte", ld[(l0 + 1) % 2], exp_lo(c));
    end
    held = data_out;
    repeat (5) @(negedge clk);
    #1;
    chk(data_out == held && ndone == d0 + 1, "R6 data holds", data_out, held);
  endtask

  initial begin
    #4000000;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int d0, c0, nl0;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    #1;
    chk(adc_convst_n && adc_cs_n && adc_rd_n, "R1 strobes in reset",
        {adc_convst_n, adc_cs_n, adc_rd_n}, 3'b111);
    chk(!data_vld && !done && !overrun && !timeout_err, "R1 flags in reset",
        {data_vld, done, overrun, timeout_err}, 0);
    do_reset();
    chk(adc_convst_n && adc_cs_n && !done && !overrun && !timeout_err, "R1 after reset",
        {adc_convst_n, adc_cs_n, done, overrun, timeout_err}, 5'b11000);

    // directed corners
    run_conv(0, 0, 1'b0, 12'h000, 1, 1, 1'b0);
    run_conv(1, 0, 1'b0, 12'hFFF, 3, 4, 1'b0);
    run_conv(4, 2, 1'b1, 12'hFFF, 2, 6, 1'b0);
    run_conv(2, 0, 1'b1, 12'h000, 1, 2, 1'b0);
    run_conv(3, 1, 1'b1, 12'hA5C, 5, 9, 1'b0);

    // random sequences
    for (int i = 0; i < 30; i++) begin
      run_conv(int'($urandom_range(0, 9)), int'($urandom_range(0, 8)), 1'($urandom_range(0, 1)),
               12'($urandom), int'($urandom_range(1, 6)), int'($urandom_range(1, 12)), 1'b0);
      repeat (12) @(negedge clk);
    end
    chk(!overrun && !timeout_err, "R7 no spurious overrun", {overrun, timeout_err}, 0);

    // gap spacing: start held high from the end of a read
    run_conv(2, 40, 1'b0, 12'h123, 2, 3, 1'b0);
    d0 = ndone;
    @(negedge clk);
    start_req = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      #1;
      if (!adc_convst_n) break;
    end
    start_req = 1'b0;
    chk(t_fall - t_rise >= 40, "R8 spacing after busy rise", t_fall - t_rise, 40);
    wait_done(d0);
    chk(ndone == d0 + 1, "R8 conversion after gap", ndone - d0, 1);

    // overrun: stray start during conversion
    do_reset();
    chk(!overrun, "R7 overrun cleared by reset", overrun, 0);
    nl0 = nlow;
    run_conv(2, 0, 1'b0, 12'h9C3, 2, 20, 1'b1);
    chk(overrun, "R7 overrun set", overrun, 1);
    chk(nlow == nl0 + 1, "R7 stray start ignored", nlow - nl0, 1);
    repeat (4) @(negedge clk);
    #1;
    chk(overrun, "R7 overrun sticky", overrun, 1);

    // timeout: busy never falls
    do_reset();
    fall_en = 1'b0;
    c0 = ncs; d0 = ndone;
    pulse_start();
    repeat (TMO + 20) @(negedge clk);
    #1;
    chk(timeout_err, "R9 timeout on missing fall", timeout_err, 1);
    chk(ncs == c0 && ndone == d0 && adc_convst_n, "R9 aborted without read",
        {ncs - c0, ndone - d0}, 0);
    fall_en = 1'b1;

    // timeout: busy never rises
    do_reset();
    chk(!timeout_err, "R10 flag cleared by reset", timeout_err, 0);
    rise_en = 1'b0;
    c0 = ncs; d0 = ndone;
    fall_dly = 2;
    pulse_start();
    repeat (TMO + 30) @(negedge clk);
    #1;
    chk(timeout_err, "R10 timeout on missing rise", timeout_err, 1);
    chk(ncs == c0 && ndone == d0, "R10 aborted without read", {ncs - c0, ndone - d0}, 0);
    rise_en = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(timeout_err, "R10 flag sticky", timeout_err, 1);

    do_reset();
    run_conv(5, 3, 1'b1, 12'h7E1, 2, 4, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule